// File: doc/BRIEF.md
# Data Transfer Timeout Watchdog

This block guards the data phase of a memory-card transfer. Once a transfer is started, it counts card-clock enables in coarse units and raises a timeout flag if no data progress is seen within a window that software programs. Each data-progress pulse restarts the window. A transfer-complete pulse or a CRC-error pulse ends the watch, and each of these sets its own flag.

The window comes from an 8-bit field whose reset value is 3. A field value of v gives a window of v+1 units. One unit is `UNIT_CYCLES` card-clock enables; the default is 2^20, and a bench can override it with a smaller value. Converting a time in nanoseconds into a field value is left to software.

All three flags sit in one 16-bit status word and stay set until cleared. Software clears a flag by writing a 1 to its bit. The usual sequence is to read the word and write the same value back.

Top module: `data_timeout_ctrl`

## Requirements
- R1: After reset the status word reads 0 and the window field holds 3, so a transfer started without programming the field times out after 4 units.
- R2: With field value v, the timeout flag (status bit 14) becomes 1 exactly (v+1)·UNIT_CYCLES enabled card-clock cycles after the cycle in which the start pulse was sampled. It reads 0 one cycle earlier.
- R3: Cycles with the card-clock enable low do not advance the window.
- R4: A data-progress pulse during an active transfer restarts the full window from zero.
- R5: A transfer-complete pulse sets status bit 12 on the next cycle and ends the watch, so no timeout follows.
- R6: A CRC-error pulse sets status bit 15 on the next cycle and ends the watch, so no timeout follows.
- R7: A status write clears exactly the bits written as 1 and leaves the bits written as 0 unchanged. Bits other than 12, 14 and 15 always read 0.
- R8: When a flag is set in the same cycle that a write clears it, the flag remains set.
- R9: When a transfer-complete pulse falls in the cycle where the window would expire, only bit 12 is set and bit 14 stays 0.
- R10: When a data-progress pulse falls in the cycle where the window would expire, no timeout is flagged and a full new window begins.
- R11: A timeout is flagged once per started transfer: while no transfer is active, bit 14 never rises.
- R12: The maximum field value of 255 gives a window of 256 units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_clk_en | input | 1 | One-cycle enable per card-clock period |
| xfer_start | input | 1 | Start pulse for a data transfer; arms the window |
| data_progress | input | 1 | Pulse on each data-progress event; restarts the window |
| xfer_done | input | 1 | Transfer-complete pulse |
| crc_error | input | 1 | Data CRC-error pulse |
| field_wr_en | input | 1 | Write strobe for the window field |
| field_wr_val | input | 8 | New window field value (window = value+1 units) |
| sts_wr_en | input | 1 | Write-one-to-clear strobe for the status word |
| sts_wr_data | input | 16 | Clear mask; a 1 clears the matching flag |
| int_status | output | 16 | Sticky flags: bit 12 complete, bit 14 timeout, bit 15 CRC error |

## Verification
Expiry can coincide with a completion pulse or with a progress pulse, and a flag being set can coincide with software clearing it. The bench drives the competing pulse on exactly the enabled cycle in which the window's last unit ends. It then checks that only the completion flag appears, or that a full fresh window follows. It also issues an all-ones clear in the same cycle as a completion pulse and checks that bit 12 survives while the other bits are cleared.

// File: rtl/dto_pkg.sv
package dto_pkg;
    localparam int FIELD_W = 8;
    localparam logic [FIELD_W-1:0] FIELD_RESET = 8'd3;
    localparam int STS_W = 16;
    localparam int BIT_DONE = 12;
    localparam int BIT_TMO = 14;
    localparam int BIT_CRC = 15;
    localparam logic [STS_W-1:0] STS_MASK =
        (STS_W'(1) << BIT_DONE) | (STS_W'(1) << BIT_TMO) | (STS_W'(1) << BIT_CRC);

    typedef struct packed {
        logic done;
        logic tmo;
        logic crc;
    } dto_events_t;
endpackage

// File: rtl/dto_unit_prescaler.sv
module dto_unit_prescaler #(
    parameter int unsigned UNIT_CYCLES = 32'd1048576
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic tick_en,
    output logic unit_tick
);
    localparam int CNT_W = (UNIT_CYCLES > 2) ? $clog2(UNIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UNIT_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic at_last;

    always_comb begin
        st_d = st_q;
        at_last = (st_q.cnt == LAST);
        unit_tick = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (run && tick_en) begin
            if (at_last) begin
                st_d.cnt = '0;
                unit_tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dto_window_counter.sv
module dto_window_counter
    import dto_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               progress,
    input  logic               stop,
    input  logic               unit_tick,
    input  logic [FIELD_W-1:0] field,
    output logic               expire,
    output logic               active
);
    typedef struct packed {
        logic               active;
        logic [FIELD_W-1:0] units;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        expire = 1'b0;
        if (stop) begin
            st_d.active = 1'b0;
            st_d.units = '0;
        end else if (start) begin
            st_d.active = 1'b1;
            st_d.units = '0;
        end else if (st_q.active && progress) begin
            st_d.units = '0;
        end else if (st_q.active && unit_tick) begin
            if (st_q.units == field) begin
                st_d.active = 1'b0;
                st_d.units = '0;
                expire = 1'b1;
            end else begin
                st_d.units = st_q.units + FIELD_W'(1);
            end
        end
    end

    assign active = st_q.active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dto_status_w1c.sv
module dto_status_w1c
    import dto_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  dto_events_t      ev,
    input  logic             wr_en,
    input  logic [STS_W-1:0] wr_data,
    output logic [STS_W-1:0] sts
);
    typedef struct packed {
        logic [STS_W-1:0] flags;
    } sts_state_t;

    sts_state_t st_d, st_q;
    logic [STS_W-1:0] set_vec;
    logic [STS_W-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        set_vec[BIT_DONE] = ev.done;
        set_vec[BIT_TMO] = ev.tmo;
        set_vec[BIT_CRC] = ev.crc;
        clr_vec = wr_en ? wr_data : '0;
        st_d.flags = ((st_q.flags & ~clr_vec) | set_vec) & STS_MASK;
    end

    assign sts = st_q.flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/data_timeout_ctrl.sv
module data_timeout_ctrl
    import dto_pkg::*;
#(
    parameter int unsigned UNIT_CYCLES = 32'd1048576
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               card_clk_en,
    input  logic               xfer_start,
    input  logic               data_progress,
    input  logic               xfer_done,
    input  logic               crc_error,
    input  logic               field_wr_en,
    input  logic [FIELD_W-1:0] field_wr_val,
    input  logic               sts_wr_en,
    input  logic [STS_W-1:0]   sts_wr_data,
    output logic [STS_W-1:0]   int_status
);
    typedef struct packed {
        logic [FIELD_W-1:0] field;
    } cfg_state_t;

    cfg_state_t  cfg_d, cfg_q;
    logic        win_active;
    logic        win_expire;
    logic        unit_tick;
    logic        stop_any;
    logic        pre_clear;
    dto_events_t ev;

    always_comb begin
        cfg_d = cfg_q;
        if (field_wr_en) begin
            cfg_d.field = field_wr_val;
        end
        stop_any = xfer_done | crc_error;
        pre_clear = xfer_start | data_progress | stop_any;
        ev.done = xfer_done;
        ev.crc = crc_error;
        ev.tmo = win_expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.field <= FIELD_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    dto_unit_prescaler #(.UNIT_CYCLES(UNIT_CYCLES)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (win_active),
        .clear    (pre_clear),
        .tick_en  (card_clk_en),
        .unit_tick(unit_tick)
    );

    dto_window_counter u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (xfer_start),
        .progress (data_progress),
        .stop     (stop_any),
        .unit_tick(unit_tick),
        .field    (cfg_q.field),
        .expire   (win_expire),
        .active   (win_active)
    );

    dto_status_w1c u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .wr_en  (sts_wr_en),
        .wr_data(sts_wr_data),
        .sts    (int_status)
    );
endmodule

// File: rtl/dto_checker.sv
module dto_checker
    import dto_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_start,
    input logic             xfer_done,
    input logic             crc_error,
    input logic             sts_wr_en,
    input logic [STS_W-1:0] sts_wr_data,
    input logic [STS_W-1:0] int_status,
    input logic             active
);
    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status & ~STS_MASK) == '0);

    // R5
    done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> int_status[BIT_DONE]);

    // R6
    crc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |=> int_status[BIT_CRC]);

    // R9
    done_blocks_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !$rose(int_status[BIT_TMO]));

    // R11
    idle_no_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !xfer_start) |=> !$rose(int_status[BIT_TMO]));

    // R5
    stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done || crc_error) |=> !active);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[BIT_DONE] && !(sts_wr_en && sts_wr_data[BIT_DONE])) |=> int_status[BIT_DONE]);
endmodule

bind data_timeout_ctrl dto_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_done  (xfer_done),
    .crc_error  (crc_error),
    .sts_wr_en  (sts_wr_en),
    .sts_wr_data(sts_wr_data),
    .int_status (int_status),
    .active     (win_active)
);

// File: tb/data_timeout_ctrl_bench.sv
`timescale 1ns/1ps
module data_timeout_ctrl_bench;
    localparam int unsigned UNIT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_clk_en = 1'b1;
    logic        xfer_start = 1'b0;
    logic        data_progress = 1'b0;
    logic        xfer_done = 1'b0;
    logic        crc_error = 1'b0;
    logic        field_wr_en = 1'b0;
    logic [7:0]  field_wr_val = 8'd0;
    logic        sts_wr_en = 1'b0;
    logic [15:0] sts_wr_data = 16'd0;
    logic [15:0] int_status;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    data_timeout_ctrl #(.UNIT_CYCLES(UNIT)) u_data_timeout_ctrl (
        .clk(clk), .rst_n(rst_n), .card_clk_en(card_clk_en),
        .xfer_start(xfer_start), .data_progress(data_progress),
        .xfer_done(xfer_done), .crc_error(crc_error),
        .field_wr_en(field_wr_en), .field_wr_val(field_wr_val),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
        .int_status(int_status)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        sts_wr_en = 1'b1; sts_wr_data = 16'hFFFF; step(1);
        sts_wr_en = 1'b0; sts_wr_data = 16'h0000;
    endtask

    task automatic set_field(input logic [7:0] v);
        field_wr_en = 1'b1; field_wr_val = v; step(1);
        field_wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        xfer_start = 1'b1; step(1); xfer_start = 1'b0;
    endtask

    task automatic expect_window(input string req, input int n);
        pulse_start();
        step(n - 1);
        chk(req, int_status, 16'h0000);
        step(1);
        chk(req, int_status, 16'h4000);
        clear_all();
    endtask

    task automatic t_reset();
        chk("R1 reset status", int_status, 16'h0000);
        step(20);
        chk("R11 idle no timeout", int_status, 16'h0000);
        expect_window("R1 default window", 4 * UNIT);
    endtask

    task automatic t_window();
        set_field(8'd0);
        expect_window("R2 field 0", UNIT);
        set_field(8'd2);
        expect_window("R2 field 2", 3 * UNIT);
    endtask

    task automatic t_stall();
        set_field(8'd0);
        card_clk_en = 1'b0;
        pulse_start();
        for (int i = 0; i < 7; i++) begin
            card_clk_en = (i % 2 == 0);
            step(1);
            if (i == 5) chk("R3 stalled before last enable", int_status, 16'h0000);
            if (i == 6) chk("R3 fires on fourth enable", int_status, 16'h4000);
        end
        card_clk_en = 1'b1;
        clear_all();
    endtask

    task automatic t_progress();
        set_field(8'd1);
        pulse_start();
        step(5);
        data_progress = 1'b1; step(1); data_progress = 1'b0;
        step(2 * UNIT - 1);
        chk("R4 reload mid window", int_status, 16'h0000);
        step(1);
        chk("R4 full window after reload", int_status, 16'h4000);
        clear_all();
        set_field(8'd0);
        pulse_start();
        step(UNIT - 1);
        data_progress = 1'b1; step(1); data_progress = 1'b0;
        chk("R10 progress at expiry", int_status, 16'h0000);
        step(UNIT - 1);
        chk("R10 new window pending", int_status, 16'h0000);
        step(1);
        chk("R10 new window expires", int_status, 16'h4000);
        clear_all();
    endtask

    task automatic t_done();
        set_field(8'd0);
        pulse_start();
        step(2);
        xfer_done = 1'b1; step(1); xfer_done = 1'b0;
        chk("R5 complete flag", int_status, 16'h1000);
        step(20);
        chk("R5 no timeout after complete", int_status, 16'h1000);
        clear_all();
        pulse_start();
        step(UNIT - 1);
        xfer_done = 1'b1; step(1); xfer_done = 1'b0;
        chk("R9 complete beats expiry", int_status, 16'h1000);
        step(10);
        chk("R9 still no timeout", int_status, 16'h1000);
        clear_all();
    endtask

    task automatic t_crc();
        set_field(8'd0);
        pulse_start();
        step(1);
        crc_error = 1'b1; step(1); crc_error = 1'b0;
        chk("R6 crc flag", int_status, 16'h8000);
        step(20);
        chk("R6 no timeout after crc", int_status, 16'h8000);
        clear_all();
    endtask

    task automatic t_w1c();
        set_field(8'd0);
        pulse_start();
        step(UNIT);
        xfer_done = 1'b1; crc_error = 1'b1; step(1);
        xfer_done = 1'b0; crc_error = 1'b0;
        chk("R7 all flags set", int_status, 16'hD000);
        sts_wr_en = 1'b1; sts_wr_data = 16'h4000; step(1);
        sts_wr_en = 1'b0;
        chk("R7 clear only bit 14", int_status, 16'h9000);
        sts_wr_en = 1'b1; sts_wr_data = 16'h0000; step(1);
        sts_wr_en = 1'b0;
        chk("R7 zero write no effect", int_status, 16'h9000);
        sts_wr_en = 1'b1; sts_wr_data = int_status; step(1);
        sts_wr_en = 1'b0;
        chk("R7 read back write back", int_status, 16'h0000);
        step(30);
        chk("R11 timeout not repeated", int_status, 16'h0000);
    endtask

    task automatic t_set_vs_clear();
        crc_error = 1'b1; step(1); crc_error = 1'b0;
        xfer_done = 1'b1; sts_wr_en = 1'b1; sts_wr_data = 16'hFFFF; step(1);
        xfer_done = 1'b0; sts_wr_en = 1'b0;
        chk("R8 set wins over clear", int_status, 16'h1000);
        clear_all();
    endtask

    task automatic t_max();
        set_field(8'd255);
        expect_window("R12 max field", 256 * UNIT);
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_window();
        t_stall();
        t_progress();
        t_done();
        t_crc();
        t_w1c();
        t_set_vs_clear();
        t_max();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule